// File: doc/BRIEF.md
# Lockable Static Memory Chip-Select Controller

This block sits between a simple CPU request port and up to four external static memory regions. Address bits above the region offset select one region. For that region the block drives an active-low chip select, output enable and write enable, holds them for a programmed number of cycles, and returns read data on a one-cycle response pulse. A region whose data bus is narrower than the access is reached in several beats. Each beat uses the next byte address, and the read word is built little-endian.

Each region has an 8-bit setup register on a small register port. The register sets the access length, the capture style (synchronous or asynchronous), write permission and bus width. These registers are guarded by a lock. A key value written to the lock register opens them for a single update, and the lock closes again after that update.

Top module: `smc_top`

## Requirements
- R1: After reset, the setup registers at offsets 0x00, 0x04, 0x08 and 0x0C read 0xF2, 0xF2, 0x2E and 0xF6. The lock register at offset 0x20 reads 1, meaning locked. req_ready is 1 and all chip selects are high.
- R2: While locked, a register-port write to a setup register leaves its readback value unchanged.
- R3: Writing 0xA05F to the low 16 bits of offset 0x20 unlocks the block, and the lock register then reads 0. The next write to a setup register takes effect and locks the block again. A further write made without a new unlock is ignored.
- R4: Writing any other value to offset 0x20 leaves the block locked, or locks it again, so a following setup write is ignored.
- R5: Bits [7:4] of a setup register give a code c. Each beat then keeps the region's chip select low for min(c+2, 16) cycles, so codes 0xE and 0xF both give 16.
- R6: When bit 3 of a setup register is 1 (synchronous), each read beat takes one extra cycle, and read data is captured there. When bit 3 is 0, read data is captured on the last wait cycle. Writes never take the extra cycle.
- R7: When bit 2 of a setup register is 0, a write to that region never drives write enable low. The response arrives on the cycle after the request is accepted, with rsp_err set.
- R8: Bits [1:0] of a setup register set the bus width: 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. req_size selects the access size: 0 is a byte, 1 is a halfword, 2 or 3 is a word. An access is split into size/width beats, with at least one beat. The beats go to consecutive addresses that step by the width in bytes. Beat k carries data bits [k*w +: w], where w is the width in bits.
- R9: req_addr[25:24] selects the region. During an access only that region's chip select is low. The output enable is low only for reads and the write enable only for writes, and never both.
- R10: req_ready is 1 only while idle. rsp_valid is a single-cycle pulse. rsp_err is 0 for every access that is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register port select |
| reg_we | input | 1 | Register port write (1) or read (0) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Controller idle, able to accept a request |
| req_write | input | 1 | Request is a write |
| req_addr | input | 26 | Request address; [25:24] pick the region |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Write to a write-protected region |
| rsp_rdata | output | 32 | Assembled read data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 24 | Memory beat address |
| mem_wdata | output | 32 | Memory beat write data, on the low lanes for narrow widths |
| mem_rdata | input | 32 | Memory read data |

## Verification
Some rules are checked on every cycle. At most one chip select is low. Output enable and write enable are never low together, and neither is low without a chip select. A response is one cycle long. A locked setup write never changes a register, and a setup write that succeeds always leaves the block locked. A write-protected write is rejected on the cycle after acceptance. The cycle count of each beat, the capture cycle for each mode, the ordering of narrow beats, and the single-use unlock with its relocking variants all depend on sequences of transactions. Only the bench scenarios show those, and the bench compares them with expected values computed from the register contents.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [5:0]  LOCK_OFS   = 6'h20;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_SCAP, ST_RESP} smc_state_e;

  // cycles per beat from the 4-bit wait code, saturating at 16
  function automatic logic [4:0] wait_len(input logic [3:0] code);
    if (code >= 4'hE) return 5'd16;
    return {1'b0, code} + 5'd2;
  endfunction

  // log2 of bus width in bytes; reserved 11 acts as 32-bit
  function automatic logic [1:0] width_log(input logic [1:0] code);
    if (code == 2'b00) return 2'd0;
    if (code == 2'b01) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] last_beat(input logic [1:0] size, input logic [1:0] wl);
    logic [1:0] sl;
    sl = size[1] ? 2'd2 : {1'b0, size[0]};
    if (sl <= wl) return 2'd0;
    return ((sl - wl) == 2'd2) ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [31:0] merge_beat(input logic [31:0] acc, input logic [31:0] rd,
                                             input logic [1:0] wl, input logic [1:0] beat);
    logic [31:0] r;
    r = acc;
    case (wl)
      2'd0:    r[{beat, 3'b000} +: 8]    = rd[7:0];
      2'd1:    r[{beat[0], 4'b0000} +: 16] = rd[15:0];
      default: r = rd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int               N_CS    = 4,
  parameter logic [N_CS*8-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CS*8-1:0] cfg_o
);
  logic [N_CS*8-1:0] cfg_q, cfg_d;
  logic              locked_q, locked_d;
  logic              wr, lock_hit, cfg_hit, cfg_en, lock_en;
  logic [2:0]        idx;

  assign wr       = reg_en & reg_we;
  assign idx      = reg_addr[4:2];
  assign lock_hit = (reg_addr == LOCK_OFS);
  assign cfg_hit  = !reg_addr[5] && (reg_addr[1:0] == 2'b00) && (int'(idx) < N_CS);
  assign cfg_en   = wr & cfg_hit & ~locked_q;
  assign lock_en  = wr & (lock_hit | cfg_hit);

  always_comb begin
    cfg_d    = cfg_q;
    locked_d = locked_q;
    if (wr && lock_hit) begin
      locked_d = (reg_wdata != UNLOCK_KEY);
    end else if (cfg_en) begin
      locked_d = 1'b1;
      for (int i = 0; i < N_CS; i++)
        if (idx == 3'(i)) cfg_d[i*8 +: 8] = reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (lock_hit) reg_rdata[0] = locked_q;
    for (int i = 0; i < N_CS; i++)
      if (cfg_hit && idx == 3'(i)) reg_rdata[7:0] = cfg_q[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RST;
      locked_q <= 1'b1;
    end else begin
      if (cfg_en)  cfg_q    <= cfg_d;
      if (lock_en) locked_q <= locked_d;
    end
  end

  assign cfg_o = cfg_q;

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cfg_hit && locked_q) |=> $stable(cfg_q));

  // R3
  unlock_single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cfg_hit && !locked_q) |=> locked_q);
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int N_CS       = 4,
  parameter int REGION_LSB = 24,
  localparam int CS_W      = $clog2(N_CS),
  localparam int AW        = REGION_LSB + CS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CS*8-1:0]     cfg_i,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_rdata,
  output logic [N_CS-1:0]       mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [REGION_LSB-1:0] mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata
);
  smc_state_e            st_q, st_d;
  logic [CS_W-1:0]       rgn_q, rgn_d, region;
  logic [7:0]            cfg_q, cfg_d, sel_cfg;
  logic                  wr_q, wr_d, err_q, err_d;
  logic [REGION_LSB-1:0] base_q, base_d;
  logic [31:0]           wdat_q, wdat_d, data_q, data_d;
  logic [4:0]            cnt_q, cnt_d, len;
  logic [1:0]            beat_q, beat_d, last_q, last_d, wl;
  logic [2:0]            ofs;
  logic [4:0]            sh;
  logic                  active;

  assign region = req_addr[REGION_LSB +: CS_W];
  assign len    = wait_len(cfg_q[7:4]);
  assign wl     = width_log(cfg_q[1:0]);

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < N_CS; i++)
      if (region == CS_W'(i)) sel_cfg = cfg_i[i*8 +: 8];
  end

  always_comb begin
    st_d = st_q;   rgn_d = rgn_q;   cfg_d = cfg_q;   wr_d = wr_q;
    err_d = err_q; base_d = base_q; wdat_d = wdat_q; data_d = data_q;
    cnt_d = cnt_q; beat_d = beat_q; last_d = last_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        rgn_d  = region;
        cfg_d  = sel_cfg;
        wr_d   = req_write;
        base_d = req_addr[REGION_LSB-1:0];
        wdat_d = req_wdata;
        data_d = '0;
        cnt_d  = '0;
        beat_d = '0;
        last_d = last_beat(req_size, width_log(sel_cfg[1:0]));
        err_d  = req_write & ~sel_cfg[2];
        st_d   = (req_write && !sel_cfg[2]) ? ST_RESP : ST_ACC;
      end
      ST_ACC: begin
        if (cnt_q == len - 5'd1) begin
          cnt_d = '0;
          if (!wr_q && cfg_q[3]) begin
            st_d = ST_SCAP;
          end else begin
            if (!wr_q) data_d = merge_beat(data_q, mem_rdata, wl, beat_q);
            if (beat_q == last_q) st_d = ST_RESP;
            else                  beat_d = beat_q + 2'd1;
          end
        end else begin
          cnt_d = cnt_q + 5'd1;
        end
      end
      ST_SCAP: begin
        data_d = merge_beat(data_q, mem_rdata, wl, beat_q);
        if (beat_q == last_q) begin
          st_d = ST_RESP;
        end else begin
          beat_d = beat_q + 2'd1;
          st_d   = ST_ACC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rgn_q <= '0; cfg_q <= '0; wr_q <= 1'b0; err_q <= 1'b0;
      base_q <= '0; wdat_q <= '0; data_q <= '0; cnt_q <= '0; beat_q <= '0; last_q <= '0;
    end else begin
      st_q <= st_d; rgn_q <= rgn_d; cfg_q <= cfg_d; wr_q <= wr_d; err_q <= err_d;
      base_q <= base_d; wdat_q <= wdat_d; data_q <= data_d; cnt_q <= cnt_d;
      beat_q <= beat_d; last_q <= last_d;
    end
  end

  always_comb begin
    case (wl)
      2'd0:    begin ofs = {1'b0, beat_q};        sh = {beat_q, 3'b000};    end
      2'd1:    begin ofs = {beat_q[0], 2'b00} >> 1; sh = {beat_q[0], 4'b0000}; end
      default: begin ofs = 3'd0;                  sh = 5'd0;                end
    endcase
  end

  assign active    = (st_q == ST_ACC) || (st_q == ST_SCAP);
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_err   = rsp_valid & err_q;
  assign rsp_rdata = data_q;
  assign mem_cs_n  = active ? ~(N_CS'(1) << rgn_q) : '1;
  assign mem_oe_n  = ~(active & ~wr_q);
  assign mem_we_n  = ~((st_q == ST_ACC) & wr_q);
  assign mem_addr  = base_q + REGION_LSB'(ofs);
  assign mem_wdata = wdat_q >> sh;

  // R7
  wp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_write && !sel_cfg[2]) |=> (rsp_valid && rsp_err));

  // R9
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n));

  // R9
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_oe_n && !mem_we_n));

  // R9
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
#(
  parameter int                N_CS       = 4,
  parameter int                REGION_LSB = 24,
  parameter logic [N_CS*8-1:0] CFG_RST    = 32'hF6_2E_F2_F2,
  localparam int               CS_W       = $clog2(N_CS),
  localparam int               AW         = REGION_LSB + CS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_we,
  input  logic [5:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_rdata,
  output logic [N_CS-1:0]       mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [REGION_LSB-1:0] mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata
);
  logic              srst_n;
  logic [N_CS*8-1:0] cfg;

  smc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(srst_n));

  smc_cfg_regs #(.N_CS(N_CS), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(srst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_o(cfg));

  smc_seq #(.N_CS(N_CS), .REGION_LSB(REGION_LSB)) u_seq (
    .clk(clk), .rst_n(srst_n), .cfg_i(cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));
endmodule

// File: tb/smc_top_bench.sv
module smc_top_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_err = 0, we_cnt = 0;
  bit done = 1'b0, bad_ready = 1'b0, bad_cs = 1'b0;
  logic [7:0]  cfg_m [4];
  logic [31:0] wlog [int];

  smc_top u_smc_top (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [23:0] a);
    return ({8'h0, a} * 32'h9E3779B1) ^ 32'h5A5A_C3C3;
  endfunction
  function automatic int f_len(input logic [7:0] c);
    return (c[7:4] >= 4'hE) ? 16 : int'(c[7:4]) + 2;
  endfunction
  function automatic int f_wbytes(input logic [7:0] c);
    return (c[1:0] == 2'b00) ? 1 : (c[1:0] == 2'b01) ? 2 : 4;
  endfunction
  function automatic int f_beats(input logic [1:0] sz, input logic [7:0] c);
    int b = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    return (b > f_wbytes(c)) ? b / f_wbytes(c) : 1;
  endfunction
  function automatic logic [31:0] f_lane(input logic [31:0] v, input int wb);
    return (wb == 4) ? v : v & ((32'h1 << (8 * wb)) - 32'h1);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 1'b0; reg_we = 1'b0;
  endtask
  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata; reg_en = 1'b0;
  endtask
  task automatic set_cfg(input int i, input logic [7:0] v);
    reg_wr(6'h20, 16'hA05F);
    reg_wr(6'(i * 4), {8'h0, v});
    cfg_m[i] = v;
  endtask

  always @(negedge clk) if (!mem_we_n) begin
    wlog[int'(mem_addr)] = mem_wdata;
    we_cnt++;
  end
  assign mem_rdata = pat(mem_addr);

  // one access; checks cycle count, error, write strobes, data
  task automatic access(input bit w, input logic [1:0] rg, input logic [23:0] ofs,
                        input logic [1:0] sz, input logic [31:0] wd);
    logic [7:0] c = cfg_m[rg];
    int n = 0, wb = f_wbytes(c), nb = f_beats(sz, c);
    bit prot = w && !c[2];
    int exp_n = prot ? 0 : nb * (f_len(c) + ((c[3] && !w) ? 1 : 0));
    logic [31:0] exp_d = '0, act_d = '0;
    wlog.delete();
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = {rg, ofs}; req_size = sz; req_wdata = wd;
    we_cnt = 0;
    @(posedge clk); #1 req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_valid || n > 200) break;
      if (req_ready) bad_ready = 1'b1;
      if (mem_cs_n !== ~(4'b1 << rg) || mem_oe_n !== w) bad_cs = 1'b1;
      n++;
    end
    chk(prot ? "R7 cycles" : "R5 R6 cycles", n, exp_n);
    chk(prot ? "R7 err" : "R10 err", {31'b0, rsp_err}, {31'b0, prot});
    for (int b = 0; b < nb; b++) begin
      logic [23:0] ba = ofs + 24'(b * wb);
      exp_d |= f_lane(w ? (wd >> (8 * wb * b)) : pat(ba), wb) << (8 * wb * b);
      if (w && wlog.exists(int'(ba))) act_d |= f_lane(wlog[int'(ba)], wb) << (8 * wb * b);
    end
    if (prot) begin
      chk("R7 we strobes", we_cnt, 0);
    end else if (w) begin
      chk("R5 we strobes", we_cnt, nb * f_len(c));
      chk("R8 write beats", act_d, exp_d);
    end else begin
      chk("R8 read data", rsp_rdata, exp_d);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    cfg_m = '{8'hF2, 8'hF2, 8'h2E, 8'hF6};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 cs", {28'b0, mem_cs_n}, 32'hF);
    for (int i = 0; i < 4; i++) begin
      reg_rd(6'(i * 4), d);
      chk("R1 cfg default", d, {24'b0, cfg_m[i]});
    end
    reg_rd(6'h20, d); chk("R1 lock", d, 32'd1);
    // R2 locked write ignored
    reg_wr(6'h04, 16'h0000);
    reg_rd(6'h04, d); chk("R2 locked write", d, 32'hF2);
    // R3 single-use unlock
    reg_wr(6'h20, 16'hA05F);
    reg_rd(6'h20, d); chk("R3 unlocked", d, 32'd0);
    reg_wr(6'h04, 16'h0005);
    reg_rd(6'h04, d); chk("R3 write taken", d, 32'h05);
    reg_rd(6'h20, d); chk("R3 relocked", d, 32'd1);
    reg_wr(6'h04, 16'h0077);
    reg_rd(6'h04, d); chk("R3 second write", d, 32'h05);
    cfg_m[1] = 8'h05;
    // R4 wrong key relocks
    reg_wr(6'h20, 16'hA05F);
    reg_wr(6'h20, 16'h1234);
    reg_rd(6'h20, d); chk("R4 relock", d, 32'd1);
    reg_wr(6'h04, 16'h00AA);
    reg_rd(6'h04, d); chk("R4 write ignored", d, 32'h05);
    // R7 region 0 is write-protected after reset
    access(1'b1, 2'd0, 24'h000100, 2'd2, 32'hDEADBEEF);
    // R5 wait codes incl. saturation
    access(1'b0, 2'd0, 24'h000040, 2'd2, '0);
    set_cfg(0, 8'hE6); access(1'b0, 2'd0, 24'h000044, 2'd2, '0);
    set_cfg(0, 8'h06); access(1'b1, 2'd0, 24'h000048, 2'd2, 32'h01234567);
    set_cfg(0, 8'h36); access(1'b0, 2'd0, 24'h00004C, 2'd2, '0);
    // R8 reserved width 11, narrow beats
    set_cfg(3, 8'h17); access(1'b0, 2'd3, 24'h000200, 2'd2, '0);
    access(1'b0, 2'd1, 24'h000300, 2'd2, '0);
    set_cfg(1, 8'h04); access(1'b1, 2'd1, 24'h000400, 2'd2, 32'hA1B2C3D4);
    access(1'b0, 2'd1, 24'h000500, 2'd1, '0);
    // R6 synchronous read and write
    access(1'b0, 2'd2, 24'h000600, 2'd2, '0);
    access(1'b1, 2'd2, 24'h000604, 2'd2, 32'h55AA33CC);
    set_cfg(2, 8'h18); access(1'b0, 2'd2, 24'h000700, 2'd2, '0);
    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [1:0] rg = 2'($urandom);
      if ($urandom % 4 == 0) set_cfg(rg, 8'($urandom));
      access(1'($urandom), rg, 24'($urandom), 2'($urandom), $urandom);
    end
    chk("R10 ready low while busy", {31'b0, bad_ready}, 32'd0);
    chk("R9 strobes and chip select", {31'b0, bad_cs}, 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule